// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of an 8-bit successive-approximation converter that serves eight multiplexed analog inputs. A one-cycle start request arrives with a 3-bit input number. The block then holds that input number on the multiplexer select and opens a sampling window. After the window it drives trial codes to an external DAC and resolves one result bit per conversion-clock period from a one-bit comparator. It ends by publishing the 8-bit result with a one-cycle completion pulse.

The conversion clock is not a separate clock. It is a clock-enable produced by a prescaler from the system clock, dividing by 8 or by 16 according to a rate-select input. Every frame lasts exactly 31 conversion-clock periods. The first 10 are sampling, the next 8 are bit trials taken from the most significant bit down, and the remaining periods are idle padding that keep the length fixed.

Start, busy and completion are plain control pins. There is no back-pressure: the result stays in its register until the next frame overwrites it, and the completion pulse is a single-cycle event that the consumer must catch.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `done_o` and `sample_en_o` are 0, and both `result_o` and `dac_code_o` read 0x00.
- R2: A start request accepted while idle keeps `busy_o` high for exactly 31×D system cycles. D is 8 when `div_sel_i`=0 and 16 when `div_sel_i`=1, sampled when the request is accepted.
- R3: `sample_en_o` is high for exactly the first 10×D cycles of a frame and is never high outside a frame.
- R4: `chan_sel_o` takes the value of `chan_i` when a start request is accepted and holds it for the whole frame, whatever `chan_i` does afterwards.
- R5: `dac_code_o` is 0x00 during sampling. In the first cycle after sampling it is 0x80, with only the most significant bit under trial.
- R6: At each conversion-clock tick during the trial phase, the bit under trial is kept when `cmp_i`=1 and cleared when `cmp_i`=0, and the next lower bit is set for trial. When the comparator reports (input ≥ trial code), the final result equals the input code.
- R7: `done_o` is a one-cycle pulse in the cycle after `busy_o` falls. `result_o` changes only in that cycle and equals the final trial code.
- R8: A start request that arrives while `busy_o` is high is ignored. It does not lengthen the frame and does not change the selected input.
- R9: After the eighth decision, `dac_code_o` holds its value unchanged through the padding periods to the end of the frame.
- R10: Changing `div_sel_i` during a frame has no effect on that frame's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, honoured only while idle |
| chan_i | input | 3 | Analog input number to convert |
| div_sel_i | input | 1 | Conversion rate: 0 = clk/8, 1 = clk/16 |
| cmp_i | input | 1 | Comparator: 1 when analog input ≥ trial code |
| chan_sel_o | output | 3 | Multiplexer select, held for the frame |
| sample_en_o | output | 1 | Sample-and-hold window |
| dac_code_o | output | 8 | Trial code to the DAC |
| busy_o | output | 1 | Frame in progress |
| result_o | output | 8 | Last conversion result |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: 8 bits, 8 inputs, a 31-period frame and dividers of 8 and 16. At this size the full frame of either rate fits in a few hundred cycles, so every input number can be converted at both rates against several analog patterns. The patterns include the codes 0x00, 0xFF, 0x7F and 0x80, where a binary search is most likely to go wrong. A behavioural comparator turns each trial into an arithmetic expectation. The smallness of the frame also lets the bench disturb the start, input-number and rate pins in mid-frame and then count the full frame length to show that nothing moved.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SAMPLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_PAD    = 2'd3
  } sar_phase_e;

  function automatic int unsigned ceil_log2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int unsigned DIV_FAST = 8,
  parameter int unsigned DIV_SLOW = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int unsigned DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int unsigned CW = sar_pkg::ceil_log2(DIV_MAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  generate
    if (DIV_FAST == DIV_SLOW) begin : g_single
      assign limit = CW'(DIV_FAST - 1);
    end else begin : g_select
      assign limit = slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
    end
  endgenerate

  assign tick = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run) begin
      if (cnt_q == limit) cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int unsigned FRAME_LEN  = 31,
  parameter int unsigned SAMPLE_LEN = 10,
  parameter int unsigned RES_BITS   = 8,
  localparam int unsigned PW = sar_pkg::ceil_log2(FRAME_LEN),
  localparam int unsigned IW = sar_pkg::ceil_log2(RES_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic          tick,
  output logic          busy,
  output sar_phase_e    phase,
  output logic          load_msb,
  output logic          decide,
  output logic [IW-1:0] bit_idx,
  output logic          finish
);
  localparam int unsigned TRIAL_END = SAMPLE_LEN + RES_BITS;

  logic          busy_q;
  logic [PW-1:0] per_q;
  int            offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      per_q  <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      per_q  <= '0;
    end else if (busy_q && tick) begin
      if (per_q == PW'(FRAME_LEN - 1)) begin
        busy_q <= 1'b0;
        per_q  <= '0;
      end else begin
        per_q <= per_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (!busy_q)                              phase = PH_IDLE;
    else if (int'(per_q) < SAMPLE_LEN)        phase = PH_SAMPLE;
    else if (int'(per_q) < TRIAL_END)         phase = PH_TRIAL;
    else                                      phase = PH_PAD;
  end

  always_comb begin
    offset  = int'(per_q) - int'(SAMPLE_LEN);
    bit_idx = '0;
    if (phase == PH_TRIAL) bit_idx = IW'(int'(RES_BITS) - 1 - offset);
  end

  assign busy     = busy_q;
  assign load_msb = busy_q && tick && (per_q == PW'(SAMPLE_LEN - 1));
  assign decide   = busy_q && tick && (phase == PH_TRIAL);
  assign finish   = busy_q && tick && (per_q == PW'(FRAME_LEN - 1));
endmodule

// File: rtl/sar_register.sv
module sar_register #(
  parameter int unsigned RES_BITS = 8,
  localparam int unsigned IW = sar_pkg::ceil_log2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                load_msb,
  input  logic                decide,
  input  logic [IW-1:0]       bit_idx,
  input  logic                cmp,
  output logic [RES_BITS-1:0] code,
  output logic [RES_BITS-1:0] code_nxt
);
  logic [RES_BITS-1:0] code_q;

  always_comb begin
    code_nxt = code_q;
    if (clear) begin
      code_nxt = '0;
    end else if (load_msb) begin
      code_nxt = '0;
      code_nxt[RES_BITS-1] = 1'b1;
    end else if (decide) begin
      for (int i = 0; i < int'(RES_BITS); i++) begin
        if (i == int'(bit_idx) && !cmp) code_nxt[i] = 1'b0;
        if (i + 1 == int'(bit_idx))     code_nxt[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_nxt;
  end

  assign code = code_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned RES_BITS   = 8,
  parameter int unsigned CH_BITS    = 3,
  parameter int unsigned FRAME_LEN  = 31,
  parameter int unsigned SAMPLE_LEN = 10,
  parameter int unsigned DIV_FAST   = 8,
  parameter int unsigned DIV_SLOW   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [CH_BITS-1:0]  chan_i,
  input  logic                div_sel_i,
  input  logic                cmp_i,
  output logic [CH_BITS-1:0]  chan_sel_o,
  output logic                sample_en_o,
  output logic [RES_BITS-1:0] dac_code_o,
  output logic                busy_o,
  output logic [RES_BITS-1:0] result_o,
  output logic                done_o
);
  localparam int unsigned IW = sar_pkg::ceil_log2(RES_BITS);

  logic                busy;
  logic                launch;
  logic                tick;
  logic                load_msb;
  logic                decide;
  logic                finish;
  logic [IW-1:0]       bit_idx;
  sar_phase_e          phase;
  logic [RES_BITS-1:0] code;
  logic [RES_BITS-1:0] code_nxt;

  logic [CH_BITS-1:0]  chan_q;
  logic                slow_q;
  logic [RES_BITS-1:0] result_q;
  logic                done_q;

  assign launch = start_i && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      slow_q <= 1'b0;
    end else if (launch) begin
      chan_q <= chan_i;
      slow_q <= div_sel_i;
    end
  end

  sar_prescaler #(
    .DIV_FAST (DIV_FAST),
    .DIV_SLOW (DIV_SLOW)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (launch),
    .run   (busy),
    .slow  (slow_q),
    .tick  (tick)
  );

  sar_sequencer #(
    .FRAME_LEN  (FRAME_LEN),
    .SAMPLE_LEN (SAMPLE_LEN),
    .RES_BITS   (RES_BITS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .tick     (tick),
    .busy     (busy),
    .phase    (phase),
    .load_msb (load_msb),
    .decide   (decide),
    .bit_idx  (bit_idx),
    .finish   (finish)
  );

  sar_register #(
    .RES_BITS (RES_BITS)
  ) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (launch),
    .load_msb (load_msb),
    .decide   (decide),
    .bit_idx  (bit_idx),
    .cmp      (cmp_i),
    .code     (code),
    .code_nxt (code_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= finish;
      if (finish) result_q <= code_nxt;
    end
  end

  assign chan_sel_o  = chan_q;
  assign sample_en_o = (phase == PH_SAMPLE);
  assign dac_code_o  = code;
  assign busy_o      = busy;
  assign result_o    = result_q;
  assign done_o      = done_q;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int unsigned RES_BITS  = 8,
  parameter int unsigned CH_BITS   = 3,
  parameter int unsigned FRAME_LEN = 31,
  parameter int unsigned DIV_FAST  = 8,
  parameter int unsigned DIV_SLOW  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic [CH_BITS-1:0]  chan_sel_o,
  input logic                sample_en_o,
  input logic [RES_BITS-1:0] dac_code_o,
  input logic                busy_o,
  input logic [RES_BITS-1:0] result_o,
  input logic                done_o
);
  localparam int unsigned LEN_FAST = FRAME_LEN * DIV_FAST;
  localparam int unsigned LEN_SLOW = FRAME_LEN * DIV_SLOW;
  localparam int unsigned LEN_MAX  = (LEN_SLOW > LEN_FAST) ? LEN_SLOW : LEN_FAST;

  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= '0;
    else if (busy_o) run_len <= run_len + 1;
    else             run_len <= '0;
  end

  AST_FRAME_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_len < LEN_MAX)); // R2

  AST_FRAME_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_len == LEN_FAST || run_len == LEN_SLOW)); // R2

  AST_SAMPLE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |-> busy_o); // R3

  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(chan_sel_o)); // R4

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && run_len != 0) |=> $stable(chan_sel_o)); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7

  AST_DONE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o)); // R7

  AST_RESULT_IS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (result_o == dac_code_o)); // R7
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
  .RES_BITS  (RES_BITS),
  .CH_BITS   (CH_BITS),
  .FRAME_LEN (FRAME_LEN),
  .DIV_FAST  (DIV_FAST),
  .DIV_SLOW  (DIV_SLOW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .chan_sel_o  (chan_sel_o),
  .sample_en_o (sample_en_o),
  .dac_code_o  (dac_code_o),
  .busy_o      (busy_o),
  .result_o    (result_o),
  .done_o      (done_o)
);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [2:0] chan;
  logic       div_sel;
  logic       cmp;
  logic [2:0] chan_sel;
  logic       sample_en;
  logic [7:0] dac_code;
  logic       busy;
  logic [7:0] result;
  logic       done;

  logic [7:0] vin [8];

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp = (vin[chan_sel] >= dac_code);

  sar_adc_ctrl u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .chan_i      (chan),
    .div_sel_i   (div_sel),
    .cmp_i       (cmp),
    .chan_sel_o  (chan_sel),
    .sample_en_o (sample_en),
    .dac_code_o  (dac_code),
    .busy_o      (busy),
    .result_o    (result),
    .done_o      (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pattern(input int pat, input int c);
    logic [7:0] edges [8];
    edges = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01, 8'hFE, 8'h40, 8'hBF};
    case (pat)
      0:       return 8'((c * 37 + 11) & 255);
      1:       return 8'((255 - c * 29) & 255);
      2:       return edges[c];
      default: return 8'((c * 113 + 71) & 255);
    endcase
  endfunction

  task automatic run_conv(input int ch, input bit slow, input bit perturb);
    int d, n, sam;
    bit chan_bad, done_bad, res_bad, pad_bad;
    logic [7:0] prev_res, pad_code;
    d = slow ? 16 : 8;
    n = 0; sam = 0;
    chan_bad = 0; done_bad = 0; res_bad = 0; pad_bad = 0;
    pad_code = 8'h00;
    @(negedge clk);
    start = 1'b1; chan = 3'(ch); div_sel = slow;
    @(negedge clk);
    start = 1'b0;
    prev_res = result;
    while (busy && n < 2000) begin
      n++;
      if (sample_en) sam++;
      if (chan_sel != 3'(ch)) chan_bad = 1;
      if (done) done_bad = 1;
      if (result != prev_res) res_bad = 1;
      if (n == 10 * d) chk(dac_code == 8'h00, "R5 code during sampling", dac_code, 0);
      if (n == 10 * d + 1) chk(dac_code == 8'h80, "R5 first trial code", dac_code, 128);
      if (n == 18 * d + 1) pad_code = dac_code;
      if (n > 18 * d + 1 && dac_code != pad_code) pad_bad = 1;
      if (perturb && n == 40) begin
        start = 1'b1; chan = 3'((ch + 3) % 8); div_sel = ~slow;
      end
      if (perturb && n == 41) start = 1'b0;
      @(negedge clk);
    end
    chk(n == 31 * d, perturb ? "R2 R8 R10 frame length" : "R2 frame length", n, 31 * d);
    chk(sam == 10 * d, "R3 sampling window", sam, 10 * d);
    chk(!chan_bad, "R4 channel held", chan_bad, 0);
    chk(!done_bad && done, "R7 done after frame", done, 1);
    chk(!res_bad, "R7 result held mid-frame", res_bad, 0);
    chk(result == vin[ch], "R6 result", result, vin[ch]);
    chk(!pad_bad && dac_code == pad_code, "R9 padding code stable", dac_code, pad_code);
    @(negedge clk);
    chk(!done, "R7 done one cycle", done, 0);
    chk(!busy, "R8 no extra frame", busy, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; chan = '0; div_sel = 1'b0;
    for (int c = 0; c < 8; c++) vin[c] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !sample_en, "R1 reset controls", {busy, done, sample_en}, 0);
    chk(result == 8'h00 && dac_code == 8'h00, "R1 reset data", result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && result == 8'h00, "R1 after release", result, 0);

    for (int s = 0; s < 2; s++) begin
      for (int pat = 0; pat < 4; pat++) begin
        for (int c = 0; c < 8; c++) vin[c] = pattern(pat, c);
        for (int ch = 0; ch < 8; ch++) begin
          run_conv(ch, s[0], pat == 3);
        end
      end
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule